// File: doc/BRIEF.md
# CSR Window Decoder

This block connects one upstream register-access bus to several downstream register buses of the same data width. Every downstream bus gets its own address window whose size is two raised to that bus's own address width. The windows are laid out at elaboration from a parameter table, in list order, and each base is aligned to its window size. An optional per-entry alignment exponent can push a base further up, to a multiple of a larger power of two.

On each cycle the upstream address is matched against all windows. The window that contains it receives the read strobe or the write strobe, the address offset inside that window and the write data. The downstream buses answer a read one cycle after the strobe. The decoder registers which window was read, so it returns the matching answer on the next cycle. Because of this, reads issued on consecutive cycles to different windows come back in issue order. An address that falls in a gap between windows, or above the last window, strobes nothing and reads as zero.

Elaboration fails in three cases: a downstream entry declares a data width different from the decoder's, an address width is zero or wider than the upstream address, or a window runs past the top of the address space.

Top module: `csr_window_decoder`

## Requirements
- R1: Entry i with address width k covers 2^k addresses, and entries are placed in list order, each base aligned to its own size. With the default table (widths 10, 10, 8), entry 0 covers 0x0000–0x03FF and entry 1 covers 0x0400–0x07FF.
- R2: A nonzero alignment exponent n on an entry moves its base up to the next multiple of 2^n. With the default table, entry 2 has n = 12, so it covers 0x1000–0x10FF rather than starting at 0x0800.
- R3: While the write strobe is high, only the bit of `sub_w_stb` for the entry whose window holds `bus_addr` is high. That entry's `sub_addr` field carries `bus_addr` minus the window base, zero-extended. `sub_w_data` equals `bus_w_data`.
- R4: While the read strobe is high, only the bit of `sub_r_stb` for the entry whose window holds `bus_addr` is high.
- R5: One cycle after the read strobe reaches entry i, `bus_r_data` equals entry i's field of `sub_r_data`. Field i occupies bits [i*DATA_W +: DATA_W].
- R6: Reads on consecutive cycles to different entries return each entry's data on consecutive cycles, in issue order.
- R7: An address outside every window raises no downstream strobe, and a read of it returns zero on the following cycle.
- R8: In a cycle that follows a cycle with no read strobe, `bus_r_data` is zero.
- R9: At most one bit of `sub_r_stb` and at most one bit of `sub_w_stb` is high in any cycle.
- R10: While reset is asserted, `bus_r_data` is zero even if a read strobe is present and the downstream buses drive nonzero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Upstream address |
| bus_r_stb | input | 1 | Upstream read strobe |
| bus_w_stb | input | 1 | Upstream write strobe |
| bus_w_data | input | DATA_W | Upstream write data |
| bus_r_data | output | DATA_W | Read data, one cycle after the read strobe |
| sub_addr | output | N_SUB*ADDR_W | Per-entry address offset, field i at [i*ADDR_W +: ADDR_W] |
| sub_r_stb | output | N_SUB | Per-entry read strobe |
| sub_w_stb | output | N_SUB | Per-entry write strobe |
| sub_w_data | output | DATA_W | Write data shared by all entries |
| sub_r_data | input | N_SUB*DATA_W | Per-entry read data, field i at [i*DATA_W +: DATA_W] |

## Verification
The main overlap is a new read strobe landing in the same cycle as the answer to the previous read. The strobe is combinational from the current address, while the returned data is chosen by the registered selection from one cycle earlier. The bench holds the read strobe high across a run of addresses in entry 0, entry 1, entry 2 and then a gap. It checks that each cycle's data belongs to the previous cycle's address and that the gap returns zero. A second overlap is a window-edge address and its neighbour just across the edge: both are driven with the write strobe, and the bench checks that each goes to its own entry with the right offset.

// File: rtl/csr_win_pkg.sv
package csr_win_pkg;

  // round v up to a multiple of 2**sh
  function automatic longint unsigned align_up(input longint unsigned v,
                                               input int unsigned sh);
    longint unsigned step;
    step = 64'd1 << sh;
    return ((v + step - 64'd1) >> sh) << sh;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/csr_win_match.sv
module csr_win_match #(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       AW     = 10,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offset_o
);
  generate
    if (AW >= ADDR_W) begin : g_full
      assign hit_o    = 1'b1;
      assign offset_o = addr_i;
    end else begin : g_part
      localparam int unsigned HI_W = ADDR_W - AW;
      localparam logic [HI_W-1:0] TAG = BASE[ADDR_W-1:AW];
      // upper bits select the window, lower bits pass through
      assign hit_o    = (addr_i[ADDR_W-1:AW] == TAG);
      assign offset_o = {{HI_W{1'b0}}, addr_i[AW-1:0]};
    end
  endgenerate
endmodule

// File: rtl/csr_rd_return.sv
module csr_rd_return #(
  parameter int unsigned N_SUB  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SUB-1:0]        rd_stb_i,
  input  logic [N_SUB*DATA_W-1:0] sub_data_i,
  output logic [DATA_W-1:0]       r_data_o
);
  logic [N_SUB-1:0] sel_q;
  logic [N_SUB-1:0] sel_d;
  logic             sel_en;

  // next state: capture the strobed entry, clear after an idle cycle
  always_comb begin
    sel_d  = rd_stb_i;
    sel_en = (|rd_stb_i) | (|sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_comb begin
    r_data_o = '0;
    for (int i = 0; i < int'(N_SUB); i++) begin
      if (sel_q[i]) r_data_o = r_data_o | sub_data_i[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/csr_window_decoder.sv
module csr_window_decoder #(
  parameter int unsigned           ADDR_W    = 16,
  parameter int unsigned           DATA_W    = 8,
  parameter int unsigned           N_SUB     = 3,
  parameter logic [N_SUB*8-1:0]    SUB_AW    = {8'd8,  8'd10, 8'd10},
  parameter logic [N_SUB*8-1:0]    SUB_ALIGN = {8'd12, 8'd0,  8'd0},
  parameter logic [N_SUB*8-1:0]    SUB_DW    = {8'd8,  8'd8,  8'd8}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_r_stb,
  input  logic                    bus_w_stb,
  input  logic [DATA_W-1:0]       bus_w_data,
  output logic [DATA_W-1:0]       bus_r_data,
  output logic [N_SUB*ADDR_W-1:0] sub_addr,
  output logic [N_SUB-1:0]        sub_r_stb,
  output logic [N_SUB-1:0]        sub_w_stb,
  output logic [DATA_W-1:0]       sub_w_data,
  input  logic [N_SUB*DATA_W-1:0] sub_r_data
);
  import csr_win_pkg::*;

  // base address of entry idx, walking the table in order
  function automatic longint unsigned base_of(input int unsigned idx);
    longint unsigned cur;
    longint unsigned res;
    int unsigned     aw;
    int unsigned     al;
    cur = 64'd0;
    res = 64'd0;
    for (int unsigned i = 0; i < N_SUB; i++) begin
      aw  = 32'(SUB_AW[i*8 +: 8]);
      al  = 32'(SUB_ALIGN[i*8 +: 8]);
      cur = align_up(cur, umax(aw, al));
      if (i == idx) res = cur;
      cur = cur + (64'd1 << aw);
    end
    return res;
  endfunction

  localparam longint unsigned SPACE = 64'd1 << ADDR_W;

  logic             rst_int_n;
  logic [N_SUB-1:0] hit;

  csr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  generate
    for (genvar g = 0; g < int'(N_SUB); g++) begin : g_win
      localparam int unsigned     AW_G   = 32'(SUB_AW[g*8 +: 8]);
      localparam int unsigned     DW_G   = 32'(SUB_DW[g*8 +: 8]);
      localparam longint unsigned BASE_G = base_of(g);

      if (DW_G != DATA_W) begin : g_bad_dw
        $error("entry %0d data width %0d differs from decoder width %0d", g, DW_G, DATA_W);
      end
      if (AW_G == 0 || AW_G > ADDR_W) begin : g_bad_aw
        $error("entry %0d address width %0d out of range", g, AW_G);
      end
      if (BASE_G + (64'd1 << AW_G) > SPACE) begin : g_bad_fit
        $error("entry %0d window runs past the address space", g);
      end

      csr_win_match #(
        .ADDR_W(ADDR_W),
        .AW    (AW_G),
        .BASE  (ADDR_W'(BASE_G))
      ) u_match (
        .addr_i  (bus_addr),
        .hit_o   (hit[g]),
        .offset_o(sub_addr[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  assign sub_r_stb  = hit & {N_SUB{bus_r_stb}};
  assign sub_w_stb  = hit & {N_SUB{bus_w_stb}};
  assign sub_w_data = bus_w_data;

  csr_rd_return #(
    .N_SUB (N_SUB),
    .DATA_W(DATA_W)
  ) u_ret (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_stb_i  (sub_r_stb),
    .sub_data_i(sub_r_data),
    .r_data_o  (bus_r_data)
  );
endmodule

// File: rtl/csr_window_decoder_chk.sv
module csr_window_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SUB  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_q_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_r_stb,
  input logic                    bus_w_stb,
  input logic [DATA_W-1:0]       bus_w_data,
  input logic [DATA_W-1:0]       bus_r_data,
  input logic [N_SUB*ADDR_W-1:0] sub_addr,
  input logic [N_SUB-1:0]        sub_r_stb,
  input logic [N_SUB-1:0]        sub_w_stb,
  input logic [DATA_W-1:0]       sub_w_data,
  input logic [N_SUB*DATA_W-1:0] sub_r_data
);
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(sub_r_stb) && $onehot0(sub_w_stb));

  assert_wstb_source_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|sub_w_stb) |-> bus_w_stb);

  assert_rstb_source_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|sub_r_stb) |-> bus_r_stb);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_r_stb |=> (bus_r_data == '0));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_r_stb && (sub_r_stb == '0)) |=> (bus_r_data == '0));

  generate
    for (genvar i = 0; i < int'(N_SUB); i++) begin : g_ret
      assert_ret_data_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
        sub_r_stb[i] |=> (bus_r_data == sub_r_data[i*DATA_W +: DATA_W]));
    end
  endgenerate
endmodule

bind csr_window_decoder csr_window_decoder_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .N_SUB (N_SUB)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_r_stb (bus_r_stb),
  .bus_w_stb (bus_w_stb),
  .bus_w_data(bus_w_data),
  .bus_r_data(bus_r_data),
  .sub_addr  (sub_addr),
  .sub_r_stb (sub_r_stb),
  .sub_w_stb (sub_w_stb),
  .sub_w_data(sub_w_data),
  .sub_r_data(sub_r_data)
);

// File: tb/csr_window_decoder_tb.sv
`timescale 1ns/1ps
module csr_window_decoder_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int N_SUB  = 3;

  // expected window table from R1/R2
  localparam int BASE_T [N_SUB] = '{32'h0000, 32'h0400, 32'h1000};
  localparam int AW_T   [N_SUB] = '{10, 10, 8};

  logic                    clk;
  logic                    rst_n;
  logic [ADDR_W-1:0]       bus_addr;
  logic                    bus_r_stb;
  logic                    bus_w_stb;
  logic [DATA_W-1:0]       bus_w_data;
  logic [DATA_W-1:0]       bus_r_data;
  logic [N_SUB*ADDR_W-1:0] sub_addr;
  logic [N_SUB-1:0]        sub_r_stb;
  logic [N_SUB-1:0]        sub_w_stb;
  logic [DATA_W-1:0]       sub_w_data;
  logic [N_SUB*DATA_W-1:0] sub_r_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  csr_window_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_r_stb (bus_r_stb),
    .bus_w_stb (bus_w_stb),
    .bus_w_data(bus_w_data),
    .bus_r_data(bus_r_data),
    .sub_addr  (sub_addr),
    .sub_r_stb (sub_r_stb),
    .sub_w_stb (sub_w_stb),
    .sub_w_data(sub_w_data),
    .sub_r_data(sub_r_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int a);
    for (int i = 0; i < N_SUB; i++)
      if (a >= BASE_T[i] && a < BASE_T[i] + (1 << AW_T[i])) return i;
    return -1;
  endfunction

  function automatic string tag_of(input int e);
    if (e < 0)  return "R7";
    if (e == 2) return "R2";
    return "R1";
  endfunction

  task automatic t_reset();
    rst_n      = 1'b0;
    bus_addr   = '0;
    bus_r_stb  = 1'b1;
    bus_w_stb  = 1'b0;
    bus_w_data = '0;
    sub_r_data = {8'hC3, 8'hAA, 8'h55};
    repeat (3) @(negedge clk);
    chk("R10 read data in reset", 32'(bus_r_data), 32'h0);
    bus_r_stb = 1'b0;
    rst_n     = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle after reset", 32'(bus_r_data), 32'h0);
  endtask

  task automatic t_write_map(input int a, input logic [7:0] d);
    int e;
    e = exp_idx(a);
    bus_addr   = ADDR_W'(a);
    bus_w_data = d;
    bus_w_stb  = 1'b1;
    #1;
    chk({tag_of(e), " R3 write strobe"}, 32'(sub_w_stb), (e < 0) ? 32'h0 : (32'h1 << e));
    chk("R9 single write target", 32'($countones(sub_w_stb) <= 1), 32'h1);
    chk("R3 write data", 32'(sub_w_data), 32'(d));
    if (e >= 0)
      chk({tag_of(e), " R3 offset"}, 32'(sub_addr[e*ADDR_W +: ADDR_W]), 32'(a - BASE_T[e]));
    @(negedge clk);
    bus_w_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_read_one(input int a);
    int e;
    e = exp_idx(a);
    bus_addr  = ADDR_W'(a);
    bus_r_stb = 1'b1;
    #1;
    chk({tag_of(e), " R4 read strobe"}, 32'(sub_r_stb), (e < 0) ? 32'h0 : (32'h1 << e));
    @(negedge clk);
    bus_r_stb = 1'b0;
    chk((e < 0) ? "R7 unmapped read data" : "R5 read data", 32'(bus_r_data),
        (e < 0) ? 32'h0 : 32'(sub_r_data[e*DATA_W +: DATA_W]));
    @(negedge clk);
    chk("R8 data after idle", 32'(bus_r_data), 32'h0);
  endtask

  task automatic t_back_to_back();
    bus_r_stb = 1'b1;
    bus_addr  = 16'h0002;
    @(negedge clk);
    chk("R6 first of run", 32'(bus_r_data), 32'h55);
    bus_addr = 16'h0402;
    @(negedge clk);
    chk("R6 second of run", 32'(bus_r_data), 32'hAA);
    bus_addr = 16'h1005;
    @(negedge clk);
    chk("R6 third of run", 32'(bus_r_data), 32'hC3);
    bus_addr = 16'h0800;
    @(negedge clk);
    chk("R7 gap inside run", 32'(bus_r_data), 32'h0);
    bus_addr  = 16'h0003;
    sub_r_data = {8'h3C, 8'h99, 8'h66};
    @(negedge clk);
    bus_r_stb = 1'b0;
    chk("R6 back into entry 0", 32'(bus_r_data), 32'h66);
    @(negedge clk);
    chk("R8 run ended", 32'(bus_r_data), 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_map(32'h0000, 8'h11);
    t_write_map(32'h03FF, 8'h22);
    t_write_map(32'h0400, 8'h33);
    t_write_map(32'h0402, 8'h44);
    t_write_map(32'h07FF, 8'h55);
    t_write_map(32'h0800, 8'h66);
    t_write_map(32'h0FFF, 8'h77);
    t_write_map(32'h1000, 8'h88);
    t_write_map(32'h10FF, 8'h99);
    t_write_map(32'h1100, 8'hAA);
    t_write_map(32'hFFFF, 8'hBB);
    t_read_one(32'h0010);
    t_read_one(32'h0402);
    t_read_one(32'h10FF);
    t_read_one(32'h0C00);
    t_back_to_back();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule